// File: doc/BRIEF.md
# LCD and Keypad Controller I2C Port

This block is the serial front end of an LCD and keypad controller. It is an I2C slave at a fixed 7-bit address. It receives commands that set the display, standby and drive-mode controls, and it fills a 16-byte display memory. Over the same bus it returns that memory, the debounced key state and the interrupt flag. The SDA and SCL inputs arrive already synchronised to the block clock. The block pulls SDA low through an open-drain enable and never drives it high.

The first byte after the address decides what the rest of the transfer means. A command byte takes effect at once, and any further bytes in the same transfer are discarded. A pointer byte selects a place to start: the display memory, the key bytes or the flag. Bytes that follow a display pointer are stored with auto-increment. Reads stream out from the current pointer. The pointer advances only when the master acknowledges a byte, and each region wraps at its own boundary. The LCD timing logic reads the display memory through a separate combinational port.

Top module: `lcdkey_i2c_port`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1110011. Bit 0 of that byte is the direction (1 = read). Any other address gets no acknowledge and changes nothing.
- R2: After reset all control outputs are 0: display off, standby, 20x4 mode, interrupt pin off, active-low polarity, scan period 0. Every display memory byte is 0x00 and SDA is released.
- R3: A first byte of the form 1000_00DS sets the display-on output from D (bit 1) and run from S (bit 0; 1 = normal, 0 = standby). It is accepted in standby as well.
- R4: A first byte of the form 1010_0AIM loads the polarity output from A (bit 2, 1 = active-high), the interrupt-pin enable from I (bit 1) and the 16x8 mode from M (bit 0).
- R5: A first byte of the form 1111_1PPP loads the 3-bit scan period output from PPP.
- R6: A first byte 0000_AAAA sets the pointer to AAAA. Each later byte of that write transfer is stored at the pointer, and the pointer then steps by one.
- R7: During writes the pointer wraps to 0x00 after address 0x09 in 20x4 mode and after 0x0F in 16x8 mode.
- R8: Every byte that follows a command byte in the same transfer is ignored.
- R9: In standby, every first byte except the 1000_00DS command is ignored. Pointer sets, mode and period commands have no effect, and no display memory byte is written.
- R10: A read returns the byte at the pointer, MSB first. The pointer advances only on a master acknowledge, and it wraps from 0x0F to 0x00 in the display region.
- R11: Pointer 0x20, 0x21 and 0x22 return key bits 7:0, 15:8 and {0000, 19:16}, and reads wrap from 0x22 to 0x20. Pointer 0x30 returns the interrupt flag in bit 7 with bits 6:0 zero, and it does not advance.
- R12: A first byte that matches none of these forms leaves every output, the display memory and the pointer unchanged, and the bytes after it are ignored.
- R13: A START or STOP resets the byte and bit sequencing, even in the middle of a byte. SDA is released after a master not-acknowledge and after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| key_state_i | input | KEY_W (20) | Debounced key bits from the scanner |
| irq_flag_i | input | 1 | Pending key interrupt flag |
| disp_raddr_i | input | AW (4) | Display memory read address for the LCD driver |
| disp_rdata_o | output | 8 | Display memory byte at disp_raddr_i |
| disp_on_o | output | 1 | Display enable |
| run_o | output | 1 | 1 = normal operation, 0 = standby |
| mode16_o | output | 1 | 1 = 16x8 drive mode, 0 = 20x4 |
| irq_pin_en_o | output | 1 | Shared pin used as interrupt output |
| irq_high_o | output | 1 | Interrupt output active-high |
| scan_period_o | output | 3 | Key-scan period code |

## Verification
The bench targets each wrap boundary. In 20x4 mode a write starting at 0x08 must land its third byte at 0x00. A design that wraps at the wrong place would store that byte at 0x0A or skip a byte. Key reads must come back to 0x20 after 0x22. The bench reads again without a new pointer to show that a not-acknowledged byte does not move the pointer; a pointer that steps on every byte would return the wrong data. It also checks that commands sent during standby are dropped, that a trailing byte after a command is not decoded as a second command, and that a START in the middle of a byte does not misalign the next transfer.

// File: rtl/lcdkey_pkg.sv
package lcdkey_pkg;
  localparam int BYTE_W = 8;

  // first-byte opcode prefixes
  localparam logic [5:0] OP_SYS  = 6'b100000;
  localparam logic [4:0] OP_MODE = 5'b10100;
  localparam logic [4:0] OP_SCAN = 5'b11111;

  typedef enum logic [2:0] {
    BS_IDLE, BS_ADDR, BS_ADDR_ACK, BS_WR, BS_WR_ACK, BS_RD, BS_RD_MACK
  } bus_state_e;

  typedef enum logic {FR_SKIP, FR_DATA} frame_e;

  typedef struct packed {
    logic       disp_on;
    logic       run;
    logic       mode16;
    logic       irq_en;
    logic       irq_high;
    logic [2:0] period;
  } ctl_t;
endpackage

// File: rtl/lcdkey_i2c_link.sv
module lcdkey_i2c_link
  import lcdkey_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1110011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_first_o,
  output logic              rd_ack_o,
  output logic              frame_edge_o
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);

  logic scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;
  bus_state_e state_q;
  logic [BYTE_W-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic rw_q, first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // bus events, visible to assertions and the register side
  assign scl_rise     = scl_i & ~scl_q;
  assign scl_fall     = ~scl_i & scl_q;
  assign start_det    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det     = scl_i & scl_q & ~sda_q & sda_i;
  assign frame_edge_o = start_det | stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= BS_IDLE;
      sh_q       <= '0;
      cnt_q      <= '0;
      rw_q       <= 1'b0;
      first_q    <= 1'b0;
      sda_oe_o   <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
      rx_first_o <= 1'b0;
      rd_ack_o   <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      rd_ack_o   <= 1'b0;
      if (start_det) begin
        state_q  <= BS_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        state_q  <= BS_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          BS_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                state_q  <= BS_ADDR_ACK;
                sda_oe_o <= 1'b1;
                rw_q     <= sh_q[0];
              end else begin
                state_q <= BS_IDLE;
              end
            end
          end
          BS_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                state_q  <= BS_RD;
                sh_q     <= tx_data_i;
                sda_oe_o <= ~tx_data_i[BYTE_W-1];
              end else begin
                state_q  <= BS_WR;
                sda_oe_o <= 1'b0;
                first_q  <= 1'b1;
              end
            end
          end
          BS_WR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_LAST) begin
                rx_valid_o <= 1'b1;
                rx_byte_o  <= {sh_q[BYTE_W-2:0], sda_i};
                rx_first_o <= first_q;
              end
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              state_q  <= BS_WR_ACK;
              sda_oe_o <= 1'b1;
              first_q  <= 1'b0;
            end
          end
          BS_WR_ACK: begin
            if (scl_fall) begin
              state_q  <= BS_WR;
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
            end
          end
          BS_RD: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == CNT_FULL) begin
                state_q  <= BS_RD_MACK;
                sda_oe_o <= 1'b0;
              end else begin
                sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~sh_q[BYTE_W-2];
              end
            end
          end
          BS_RD_MACK: begin
            if (scl_rise) begin
              if (!sda_i) rd_ack_o <= 1'b1;
              else        state_q  <= BS_IDLE;
            end else if (scl_fall) begin
              state_q  <= BS_RD;
              cnt_q    <= '0;
              sh_q     <= tx_data_i;
              sda_oe_o <= ~tx_data_i[BYTE_W-1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R13: a STOP always leaves the data line free
  a_r13_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);

  // R13: the slave never moves SDA while SCL stays high
  a_r13_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && scl_q && !start_det && !stop_det) |=> $stable(sda_oe_o));

  // R1: a foreign address is never acknowledged
  a_r1_foreign_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BS_ADDR && scl_fall && cnt_q == CNT_FULL &&
     sh_q[BYTE_W-1:1] != DEV_ADDR && !start_det && !stop_det) |=> !sda_oe_o);

  // R10: master NACK ends the read and frees SDA
  a_r10_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BS_RD_MACK && scl_rise && sda_i && !start_det && !stop_det)
    |=> (!sda_oe_o && state_q == BS_IDLE));
endmodule

// File: rtl/lcdkey_regfile.sv
module lcdkey_regfile
  import lcdkey_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int KEY_W       = 20,
  parameter int NARROW_LAST = 9,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_first_i,
  input  logic              rd_ack_i,
  input  logic              frame_edge_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              flag_i,
  input  logic [AW-1:0]     disp_raddr_i,
  output logic [BYTE_W-1:0] disp_rdata_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output ctl_t              ctl_o
);
  localparam int KEY_BYTES = (KEY_W + BYTE_W - 1) / BYTE_W;
  localparam int KEY_PAD   = KEY_BYTES * BYTE_W;
  localparam int KIW       = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;
  localparam logic [BYTE_W-1:0] P_DISP_LAST   = BYTE_W'(DEPTH - 1);
  localparam logic [BYTE_W-1:0] P_NARROW_LAST = BYTE_W'(NARROW_LAST);
  localparam logic [BYTE_W-1:0] P_KEY_BASE    = 8'h20;
  localparam logic [BYTE_W-1:0] P_KEY_TOP     = BYTE_W'(32'h20 + KEY_BYTES - 1);
  localparam logic [BYTE_W-1:0] P_FLAG        = 8'h30;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] ptr_q;
  frame_e phase_q;
  ctl_t ctl_q;

  logic [KEY_PAD-1:0] key_pad;
  logic [BYTE_W-1:0] key_bytes [KEY_BYTES];
  logic [DEPTH*BYTE_W-1:0] mem_flat;
  logic in_key, in_disp, data_wr;

  assign key_pad = KEY_PAD'(key_i);
  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_keyb
    assign key_bytes[g] = key_pad[g*BYTE_W +: BYTE_W];
  end
  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign mem_flat[g*BYTE_W +: BYTE_W] = mem[g];
  end

  // read-side pointer step: display wraps at the memory end, keys at their top
  function automatic logic [BYTE_W-1:0] rd_step(input logic [BYTE_W-1:0] p);
    if (p <= P_DISP_LAST)
      return (p == P_DISP_LAST) ? '0 : p + BYTE_W'(1);
    else if (p >= P_KEY_BASE && p <= P_KEY_TOP)
      return (p == P_KEY_TOP) ? P_KEY_BASE : p + BYTE_W'(1);
    else
      return p;
  endfunction

  // write-side pointer step: last address depends on the drive mode
  function automatic logic [BYTE_W-1:0] wr_step(input logic [BYTE_W-1:0] p,
                                                input logic m16);
    logic [BYTE_W-1:0] last;
    last = m16 ? P_DISP_LAST : P_NARROW_LAST;
    return (p >= last) ? '0 : p + BYTE_W'(1);
  endfunction

  assign in_disp = (ptr_q <= P_DISP_LAST);
  assign in_key  = (ptr_q >= P_KEY_BASE) && (ptr_q <= P_KEY_TOP);
  assign data_wr = rx_valid_i && !rx_first_i && phase_q == FR_DATA &&
                   ctl_q.run && in_disp && !frame_edge_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      phase_q <= FR_SKIP;
      ctl_q   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (frame_edge_i) begin
      phase_q <= FR_SKIP;
    end else if (rx_valid_i && rx_first_i) begin
      phase_q <= FR_SKIP;
      if (rx_byte_i[7:2] == OP_SYS) begin
        ctl_q.disp_on <= rx_byte_i[1];
        ctl_q.run     <= rx_byte_i[0];
      end else if (ctl_q.run) begin
        if (rx_byte_i <= P_DISP_LAST || rx_byte_i == P_KEY_BASE ||
            rx_byte_i == P_FLAG) begin
          ptr_q   <= rx_byte_i;
          phase_q <= FR_DATA;
        end else if (rx_byte_i[7:3] == OP_MODE) begin
          ctl_q.irq_high <= rx_byte_i[2];
          ctl_q.irq_en   <= rx_byte_i[1];
          ctl_q.mode16   <= rx_byte_i[0];
        end else if (rx_byte_i[7:3] == OP_SCAN) begin
          ctl_q.period <= rx_byte_i[2:0];
        end
      end
    end else if (data_wr) begin
      mem[ptr_q[AW-1:0]] <= rx_byte_i;
      ptr_q <= wr_step(ptr_q, ctl_q.mode16);
    end else if (rd_ack_i) begin
      ptr_q <= rd_step(ptr_q);
    end
  end

  always_comb begin
    if (in_disp)             tx_data_o = mem[ptr_q[AW-1:0]];
    else if (in_key)         tx_data_o = key_bytes[KIW'(ptr_q - P_KEY_BASE)];
    else if (ptr_q == P_FLAG) tx_data_o = {flag_i, {(BYTE_W-1){1'b0}}};
    else                     tx_data_o = '0;
  end

  assign disp_rdata_o = mem[disp_raddr_i];
  assign ctl_o        = ctl_q;

  // R9: standby freezes display memory
  a_r9_standby_ram_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.run |=> $stable(mem_flat));

  // R9: standby freezes mode and period fields
  a_r9_standby_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.run |=> $stable({ctl_q.mode16, ctl_q.irq_en, ctl_q.irq_high, ctl_q.period}));

  // R11: key reads wrap back to the first key byte
  a_r11_key_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack_i && ptr_q == P_KEY_TOP && !frame_edge_i && !rx_valid_i)
    |=> ptr_q == P_KEY_BASE);

  // R10: display reads wrap to zero
  a_r10_disp_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack_i && ptr_q == P_DISP_LAST && !frame_edge_i && !rx_valid_i)
    |=> ptr_q == '0);

  // R7: 20x4 writes wrap after the narrow last address
  a_r7_narrow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ctl_q.mode16 && ptr_q == P_NARROW_LAST) |=> ptr_q == '0);

  // R11: the pointer never leaves the three legal regions
  a_r11_ptr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_disp || in_key || ptr_q == P_FLAG));
endmodule

// File: rtl/lcdkey_i2c_port.sv
module lcdkey_i2c_port
  import lcdkey_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1110011,
  parameter int         DEPTH       = 16,
  parameter int         KEY_W       = 20,
  parameter int         NARROW_LAST = 9,
  localparam int        AW          = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [KEY_W-1:0] key_state_i,
  input  logic             irq_flag_i,
  input  logic [AW-1:0]    disp_raddr_i,
  output logic [7:0]       disp_rdata_o,
  output logic             disp_on_o,
  output logic             run_o,
  output logic             mode16_o,
  output logic             irq_pin_en_o,
  output logic             irq_high_o,
  output logic [2:0]       scan_period_o
);
  logic              rx_valid, rx_first, rd_ack, frame_edge;
  logic [BYTE_W-1:0] rx_byte, tx_data;
  ctl_t              ctl;

  lcdkey_i2c_link #(.DEV_ADDR(DEV_ADDR)) link_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .tx_data_i    (tx_data),
    .sda_oe_o     (sda_oe_o),
    .rx_valid_o   (rx_valid),
    .rx_byte_o    (rx_byte),
    .rx_first_o   (rx_first),
    .rd_ack_o     (rd_ack),
    .frame_edge_o (frame_edge)
  );

  lcdkey_regfile #(.DEPTH(DEPTH), .KEY_W(KEY_W), .NARROW_LAST(NARROW_LAST)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid_i   (rx_valid),
    .rx_byte_i    (rx_byte),
    .rx_first_i   (rx_first),
    .rd_ack_i     (rd_ack),
    .frame_edge_i (frame_edge),
    .key_i        (key_state_i),
    .flag_i       (irq_flag_i),
    .disp_raddr_i (disp_raddr_i),
    .disp_rdata_o (disp_rdata_o),
    .tx_data_o    (tx_data),
    .ctl_o        (ctl)
  );

  assign disp_on_o     = ctl.disp_on;
  assign run_o         = ctl.run;
  assign mode16_o      = ctl.mode16;
  assign irq_pin_en_o  = ctl.irq_en;
  assign irq_high_o    = ctl.irq_high;
  assign scan_period_o = ctl.period;
endmodule

// File: tb/lcdkey_i2c_port_tb_top.sv
module lcdkey_i2c_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [19:0] key_state = '0;
  logic irq_flag = 1'b0;
  logic [3:0] raddr = '0;
  logic [7:0] rdata;
  logic disp_on, run, mode16, irq_en, irq_high;
  logic [2:0] period;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  lcdkey_i2c_port dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .key_state_i(key_state), .irq_flag_i(irq_flag), .disp_raddr_i(raddr),
    .disp_rdata_o(rdata), .disp_on_o(disp_on), .run_o(run), .mode16_o(mode16),
    .irq_pin_en_o(irq_en), .irq_high_o(irq_high), .scan_period_o(period));

  // {cmd, expected {disp_on, run, mode16, irq_en, irq_high, period}}
  localparam logic [15:0] CFG_VEC [13] = '{
    16'h81_40, 16'h83_C0, 16'hA1_E0, 16'hA6_D8, 16'hFD_DD, 16'hC5_DD,
    16'hA3_F5, 16'h82_B5, 16'hA0_B5, 16'hF9_B5, 16'h81_75, 16'hA0_45,
    16'hF8_40};

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~mack);
  endtask

  task automatic wr2(input logic [7:0] b0);
    logic ack;
    bus_start(); put_byte(8'hE6, ack); put_byte(b0, ack); bus_stop();
  endtask

  task automatic mem_at(input logic [3:0] a, output logic [7:0] v);
    raddr = a; @(negedge clk); v = rdata;
  endtask

  function automatic logic [7:0] ctl_now();
    return {disp_on, run, mode16, irq_en, irq_high, period};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog: got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] v;
    string tag;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    check8("R2 ctl after reset", ctl_now(), 8'h00);
    mem_at(4'h0, v); check8("R2 ram[0] after reset", v, 8'h00);
    check8("R2 sda released", {7'b0, sda_oe}, 8'h00);

    // R1 foreign address not acknowledged
    bus_start(); put_byte(8'hE4, ack); bus_stop();
    check8("R1 foreign address ack", {7'b0, ack}, 8'h00);

    // R9 display write while in standby is dropped
    bus_start(); put_byte(8'hE6, ack);
    check8("R1 own address ack", {7'b0, ack}, 8'h01);
    put_byte(8'h00, ack); put_byte(8'hAA, ack); bus_stop();
    mem_at(4'h0, v); check8("R9 standby ram write ignored", v, 8'h00);

    // table of configuration commands: R3 R4 R5 R9 R12
    for (int k = 0; k < 13; k++) begin
      logic was_run;
      logic [7:0] cmd;
      was_run = run;
      cmd = CFG_VEC[k][15:8];
      if (cmd[7:2] == 6'b100000) tag = "R3 system command";
      else if (!was_run) tag = "R9 standby command ignored";
      else if (cmd[7:3] == 5'b10100) tag = "R4 mode command";
      else if (cmd[7:3] == 5'b11111) tag = "R5 period command";
      else tag = "R12 undefined command";
      wr2(cmd);
      check8(tag, ctl_now(), CFG_VEC[k][7:0]);
    end

    // R6 R7 20x4 write with wrap after 0x09
    bus_start(); put_byte(8'hE6, ack); put_byte(8'h08, ack);
    put_byte(8'h11, ack); put_byte(8'h22, ack); put_byte(8'h33, ack); bus_stop();
    mem_at(4'h8, v); check8("R6 write at 0x08", v, 8'h11);
    mem_at(4'h9, v); check8("R6 write at 0x09", v, 8'h22);
    mem_at(4'h0, v); check8("R7 20x4 wrap to 0x00", v, 8'h33);
    mem_at(4'hA, v); check8("R7 20x4 no write at 0x0A", v, 8'h00);

    // R8 trailing byte after a command is ignored
    bus_start(); put_byte(8'hE6, ack); put_byte(8'hA1, ack); put_byte(8'h83, ack); bus_stop();
    check8("R8 command then trailing byte", ctl_now(), 8'h60);

    // R7 16x8 write with wrap after 0x0F
    bus_start(); put_byte(8'hE6, ack); put_byte(8'h0E, ack);
    put_byte(8'h44, ack); put_byte(8'h55, ack); put_byte(8'h66, ack); bus_stop();
    mem_at(4'hE, v); check8("R7 16x8 write at 0x0E", v, 8'h44);
    mem_at(4'hF, v); check8("R7 16x8 write at 0x0F", v, 8'h55);
    mem_at(4'h0, v); check8("R7 16x8 wrap to 0x00", v, 8'h66);

    // R10 display read with wrap, pointer set then repeated start
    bus_start(); put_byte(8'hE6, ack); put_byte(8'h0E, ack);
    bus_start(); put_byte(8'hE7, ack);
    check8("R1 read address ack", {7'b0, ack}, 8'h01);
    get_byte(v, 1'b1); check8("R10 read 0x0E", v, 8'h44);
    get_byte(v, 1'b1); check8("R10 read 0x0F", v, 8'h55);
    get_byte(v, 1'b0); check8("R10 read wraps to 0x00", v, 8'h66);
    check8("R13 sda released after nack", {7'b0, sda_oe}, 8'h00);
    bus_stop();

    // R10 NACKed byte did not move the pointer
    bus_start(); put_byte(8'hE7, ack); get_byte(v, 1'b0); bus_stop();
    check8("R10 pointer held after nack", v, 8'h66);

    // R11 key bytes and wrap
    key_state = 20'h93C5A;
    bus_start(); put_byte(8'hE6, ack); put_byte(8'h20, ack);
    bus_start(); put_byte(8'hE7, ack);
    get_byte(v, 1'b1); check8("R11 key byte 0", v, 8'h5A);
    get_byte(v, 1'b1); check8("R11 key byte 1", v, 8'h3C);
    get_byte(v, 1'b1); check8("R11 key byte 2", v, 8'h09);
    get_byte(v, 1'b0); check8("R11 key wrap to byte 0", v, 8'h5A);
    bus_stop();

    // R11 flag register, no advance
    irq_flag = 1'b1;
    bus_start(); put_byte(8'hE6, ack); put_byte(8'h30, ack);
    bus_start(); put_byte(8'hE7, ack);
    get_byte(v, 1'b1); check8("R11 flag read", v, 8'h80);
    get_byte(v, 1'b0); check8("R11 flag read repeat", v, 8'h80);
    bus_stop();

    // R13 START in the middle of a byte resynchronises
    bus_start(); put_byte(8'hE6, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start(); put_byte(8'hE6, ack); put_byte(8'h05, ack); put_byte(8'h99, ack); bus_stop();
    mem_at(4'h5, v); check8("R13 write after mid-byte start", v, 8'h99);

    // R12 undefined first byte and its trailing byte change nothing
    bus_start(); put_byte(8'hE6, ack); put_byte(8'h40, ack); put_byte(8'h12, ack); bus_stop();
    check8("R12 ctl unchanged", ctl_now(), 8'h60);
    mem_at(4'h6, v); check8("R12 ram[6] unchanged", v, 8'h00);
    bus_start(); put_byte(8'hE7, ack); get_byte(v, 1'b0); bus_stop();
    check8("R12 pointer unchanged", v, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule